// File: doc/BRIEF.md
# Asynchronous Bus Read Cycle Sequencer

This block is the master side of a single read cycle on an asynchronous 32-bit bus. A requester presents an address, a transfer size, a three-bit function code and a cache-inhibit flag. The block then steps through a fixed series of half-clock bus states and drives the strobes, the buffer enable and the held address lines. It returns the captured read data, together with the cache-inhibit answer from the slave, in a one-clock done pulse.

The block runs from a single clock whose period equals one half-clock bus state, which is the double-rate form of the bus clock. Each rising edge therefore advances one state.

The named states are:
- `ST_IDLE`: no cycle is running.
- `ST_S0`: cycle start.
- `ST_S1`: strobes asserted.
- `ST_S2`: buffer enable asserted.
- `ST_W1` and `ST_W2`: a wait pair.
- `ST_S3` and `ST_S4`: the data phase.
- `ST_S5`: strobes negated.

The transitions are:
- IDLE→S0 on a request.
- S0→S1→S2.
- S2→S3 if an acknowledge is recognized, otherwise S2→W1.
- W1→W2.
- W2→S3 if an acknowledge is recognized, otherwise W2→W1.
- S3→S4→S5→IDLE.

The two acknowledge lines pass through a synchronizer chain of `SYNC_STAGES` flops. An acknowledge is recognized only when it is armed, which means the synchronized lines have both been seen low since the last acknowledge was recognized.

Top module: `abus_read_seq`

## Requirements
- R1: A request (`req_i` high) is taken only in ST_IDLE, and the state is ST_S0 after the next edge. `ecs_o` is high only in ST_S0, for one clock. `req_i` in any other state has no effect.
- R2: `as_o` and `ds_o` are high in ST_S1, ST_S2, ST_W1, ST_W2, ST_S3 and ST_S4, and low in every other state, including ST_S5.
- R3: `dben_o` is high in ST_S2, ST_W1, ST_W2, ST_S3 and ST_S4, and low otherwise.
- R4: At the last clock of ST_S2 or ST_W2, a recognized acknowledge moves to ST_S3. Otherwise the block goes to ST_W1, so wait states come in pairs of two states. Either line alone (`ack_i` = 01 or 10) counts as an acknowledge.
- R5: A change on `ack_i` reaches the recognition logic after exactly 2 rising edges (`SYNC_STAGES` = 2).
- R6: `ci_in_i` is sampled at the edge that leaves ST_S3. The sampled value appears on `ci_o` and is held until the next such edge.
- R7: `data_i` is sampled at the edge that leaves ST_S4. The sampled value appears on `rdata_o`.
- R8: `addr_o`, `size_o` and `fc_o` take the request values at acceptance and stay unchanged through ST_S5. `rw_o` is always 1 (read).
- R9: After an acknowledge is recognized, no acknowledge is recognized again until both synchronized lines have been low at one edge. An acknowledge held high into the next cycle therefore causes wait states.
- R10: `done_o` is high for exactly one clock, in ST_S5, and `rdata_o` and `ci_o` are valid in that clock.
- R11: `ciout_o` equals the request's cache-inhibit flag in every non-idle state, and is 0 in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one period equals one bus state |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a read cycle (taken in idle only) |
| req_addr_i | input | 32 | Read address |
| req_size_i | input | 2 | Transfer size code |
| req_fc_i | input | 3 | Function code |
| req_ci_i | input | 1 | Request-side cache-inhibit flag |
| ack_i | input | 2 | Asynchronous size-acknowledge lines |
| ci_in_i | input | 1 | Synchronous cache-inhibit answer from the slave |
| data_i | input | 32 | Read data bus |
| addr_o | output | 32 | Held address |
| size_o | output | 2 | Held size |
| fc_o | output | 3 | Held function code |
| rw_o | output | 1 | Read/write line, always read |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| dben_o | output | 1 | Data buffer enable |
| ecs_o | output | 1 | Cycle-start strobe |
| ciout_o | output | 1 | Cache-inhibit out during the cycle |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Captured read data |
| ci_o | output | 1 | Captured cache-inhibit answer |

## Verification
The bench applies several acknowledge patterns:
- **Acknowledge present from the request onward.** This separates a zero-wait cycle from an off-by-one synchronizer latency.
- **Acknowledge arriving late.** This shows whether wait states come in pairs and whether recognition happens only at the end of ST_S2 and ST_W2.
- **Acknowledge on each line alone.** This shows that either line is enough.
- **Acknowledge left asserted into a following request.** This shows whether the re-arm rule blocks a stale acknowledge.

The data bus and the cache-inhibit input change on every clock, so a capture made one state early or late gives a wrong value. Stray requests during a cycle show that only the idle state takes requests.

// File: rtl/abus_pkg.sv
package abus_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_S5,
        ST_W1,
        ST_W2
    } bus_state_e;

    localparam int ACK_LINES = 2;
endpackage

// File: rtl/abus_ack_sync.sv
module abus_ack_sync
    import abus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ACK_LINES-1:0] ack_i,
    input  logic                 take_i,
    output logic                 seen_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][ACK_LINES-1:0] st_q;
    logic                                  armed_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) st_q[g] <= '0;
                    else        st_q[g] <= ack_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) st_q[g] <= '0;
                    else        st_q[g] <= st_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)                 armed_q <= 1'b0;
        else if (take_i)            armed_q <= 1'b0;
        else if (st_q[LAST] == '0)  armed_q <= 1'b1;
    end

    assign seen_o = armed_q && (st_q[LAST] != '0);

    // R9: an acknowledge just taken is not recognized in the next clock
    assert_no_rerecog_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !seen_o);
endmodule

// File: rtl/abus_read_fsm.sv
module abus_read_fsm
    import abus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_seen_i,
    output logic take_o,
    output logic accept_o,
    output logic ci_sample_o,
    output logic data_sample_o,
    output logic active_o,
    output logic as_o,
    output logic ds_o,
    output logic dben_o,
    output logic ecs_o,
    output logic done_o
);
    bus_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        take_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_S0;
            ST_S0:   state_d = ST_S1;
            ST_S1:   state_d = ST_S2;
            ST_S2, ST_W2: begin
                if (ack_seen_i) begin
                    state_d = ST_S3;
                    take_o  = 1'b1;
                end else begin
                    state_d = ST_W1;
                end
            end
            ST_W1:   state_d = ST_W2;
            ST_S3:   state_d = ST_S4;
            ST_S4:   state_d = ST_S5;
            ST_S5:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        as_o          = 1'b0;
        dben_o        = 1'b0;
        ecs_o         = 1'b0;
        done_o        = 1'b0;
        ci_sample_o   = 1'b0;
        data_sample_o = 1'b0;
        active_o      = 1'b1;
        unique case (state_q)
            ST_IDLE: active_o = 1'b0;
            ST_S0:   ecs_o = 1'b1;
            ST_S1:   as_o = 1'b1;
            ST_S2, ST_W1, ST_W2: begin
                as_o   = 1'b1;
                dben_o = 1'b1;
            end
            ST_S3: begin
                as_o        = 1'b1;
                dben_o      = 1'b1;
                ci_sample_o = 1'b1;
            end
            ST_S4: begin
                as_o          = 1'b1;
                dben_o        = 1'b1;
                data_sample_o = 1'b1;
            end
            ST_S5:   done_o = 1'b1;
            default: active_o = 1'b0;
        endcase
    end

    assign ds_o     = as_o;
    assign accept_o = (state_q == ST_IDLE) && req_i;

    assert_start_one_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ecs_o |=> !ecs_o);
    assert_wait_without_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S2 && !ack_seen_i) |=> (state_q == ST_W1));
    assert_strobe_drop_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_o) |-> done_o);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/abus_capture.sv
module abus_capture #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 2,
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          ci_sample_i,
    input  logic          data_sample_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [SW-1:0] req_size_i,
    input  logic [FW-1:0] req_fc_i,
    input  logic          req_ci_i,
    input  logic          ci_in_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] size_o,
    output logic [FW-1:0] fc_o,
    output logic          ciflag_o,
    output logic [DW-1:0] rdata_o,
    output logic          ci_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o   <= '0;
            size_o   <= '0;
            fc_o     <= '0;
            ciflag_o <= 1'b0;
        end else if (accept_i) begin
            addr_o   <= req_addr_i;
            size_o   <= req_size_i;
            fc_o     <= req_fc_i;
            ciflag_o <= req_ci_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           ci_o <= 1'b0;
        else if (ci_sample_i) ci_o <= ci_in_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             rdata_o <= '0;
        else if (data_sample_i) rdata_o <= data_i;
    end

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(addr_o));
endmodule

// File: rtl/abus_read_seq.sv
module abus_read_seq
    import abus_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int SW          = 2,
    parameter int FW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [AW-1:0]        req_addr_i,
    input  logic [SW-1:0]        req_size_i,
    input  logic [FW-1:0]        req_fc_i,
    input  logic                 req_ci_i,
    input  logic [ACK_LINES-1:0] ack_i,
    input  logic                 ci_in_i,
    input  logic [DW-1:0]        data_i,
    output logic [AW-1:0]        addr_o,
    output logic [SW-1:0]        size_o,
    output logic [FW-1:0]        fc_o,
    output logic                 rw_o,
    output logic                 as_o,
    output logic                 ds_o,
    output logic                 dben_o,
    output logic                 ecs_o,
    output logic                 ciout_o,
    output logic                 done_o,
    output logic [DW-1:0]        rdata_o,
    output logic                 ci_o
);
    logic seen, take, accept, ci_smp, data_smp, active, ciflag;

    abus_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ack_i),
        .take_i (take),
        .seen_o (seen)
    );

    abus_read_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .ack_seen_i    (seen),
        .take_o        (take),
        .accept_o      (accept),
        .ci_sample_o   (ci_smp),
        .data_sample_o (data_smp),
        .active_o      (active),
        .as_o          (as_o),
        .ds_o          (ds_o),
        .dben_o        (dben_o),
        .ecs_o         (ecs_o),
        .done_o        (done_o)
    );

    abus_capture #(.AW(AW), .DW(DW), .SW(SW), .FW(FW)) cap_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept),
        .ci_sample_i   (ci_smp),
        .data_sample_i (data_smp),
        .req_addr_i    (req_addr_i),
        .req_size_i    (req_size_i),
        .req_fc_i      (req_fc_i),
        .req_ci_i      (req_ci_i),
        .ci_in_i       (ci_in_i),
        .data_i        (data_i),
        .addr_o        (addr_o),
        .size_o        (size_o),
        .fc_o          (fc_o),
        .ciflag_o      (ciflag),
        .rdata_o       (rdata_o),
        .ci_o          (ci_o)
    );

    assign rw_o    = 1'b1;
    assign ciout_o = active && ciflag;

    assert_ciout_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !ciout_o);
endmodule

// File: tb/abus_read_seq_tb_top.sv
module abus_read_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [1:0]  req_size_i = '0;
    logic [2:0]  req_fc_i = '0;
    logic        req_ci_i = 1'b0;
    logic [1:0]  ack_i = '0;
    logic        ci_in_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [31:0] addr_o, rdata_o;
    logic [1:0]  size_o;
    logic [2:0]  fc_o;
    logic        rw_o, as_o, ds_o, dben_o, ecs_o, ciout_o, done_o, ci_o;

    abus_read_seq dut_i (.*);

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit started = 0;
    string tst = "reset";

    // behavioural model: phase 0 idle, 1..6 = S0..S5, 7/8 = wait pair
    int          m_ph = 0;
    bit [1:0]    m_q1 = 0, m_q2 = 0;
    bit          m_armed = 0;
    bit [31:0]   m_addr = 0, m_data = 0;
    bit [1:0]    m_size = 0;
    bit [2:0]    m_fc = 0;
    bit          m_cif = 0, m_ci = 0;

    always @(posedge clk) begin
        int  nph;
        bit  rec;
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_ph = 0; m_q1 = 0; m_q2 = 0; m_armed = 0;
            m_addr = 0; m_data = 0; m_size = 0; m_fc = 0; m_cif = 0; m_ci = 0;
        end else begin
            rec = m_armed && (m_q2 != 0);
            nph = m_ph;
            case (m_ph)
                0: if (req_i) begin
                       nph = 1; m_addr = req_addr_i; m_size = req_size_i;
                       m_fc = req_fc_i; m_cif = req_ci_i;
                   end
                1: nph = 2;
                2: nph = 3;
                3, 8: nph = rec ? 4 : 7;
                7: nph = 8;
                4: begin nph = 5; m_ci = ci_in_i; end
                5: begin nph = 6; m_data = data_i; end
                default: nph = 0;
            endcase
            if ((m_ph == 3 || m_ph == 8) && rec) m_armed = 0;
            else if (m_q2 == 0)                   m_armed = 1;
            m_q2 = m_q1;
            m_q1 = ack_i;
            m_ph = nph;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d: actual %h expected %h", tag, tst, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            bit strb, buf_en, wt;
            strb   = (m_ph >= 2 && m_ph <= 5) || m_ph >= 7;
            buf_en = (m_ph >= 3 && m_ph <= 5) || m_ph >= 7;
            wt     = (m_ph >= 7);
            chk(wt ? "R4 wait strobe" : "R2 as", {31'b0, as_o}, {31'b0, strb});
            chk("R2 ds", {31'b0, ds_o}, {31'b0, strb});
            chk(wt ? "R4 wait buffer" : "R3 dben", {31'b0, dben_o}, {31'b0, buf_en});
            chk("R1 ecs", {31'b0, ecs_o}, {31'b0, m_ph == 1});
            chk("R10 done", {31'b0, done_o}, {31'b0, m_ph == 6});
            chk("R11 ciout", {31'b0, ciout_o}, {31'b0, (m_ph != 0) && m_cif});
            chk("R8 rw", {31'b0, rw_o}, 32'd1);
            if (m_ph != 0) begin
                chk("R8 addr", addr_o, m_addr);
                chk("R8 size", {30'b0, size_o}, {30'b0, m_size});
                chk("R8 fc", {29'b0, fc_o}, {29'b0, m_fc});
            end
            if (m_ph == 6) begin
                chk("R7 rdata", rdata_o, m_data);
                chk("R6 ci", {31'b0, ci_o}, {31'b0, m_ci});
            end
            // changing inputs every clock expose capture-timing errors
            data_i  <= 32'h5A000000 ^ (cyc * 32'h01030507);
            ci_in_i <= cyc[1] ^ cyc[0];
        end
    end

    task automatic wait_ph(int ph);
        while (m_ph != ph) @(negedge clk);
    endtask

    // one read: ack value, clocks until ack, clocks ack held after done (-1 keeps it)
    task automatic run(bit [1:0] av, int dly, int hold, bit cif, int stray);
        @(negedge clk);
        req_i = 1; req_addr_i = 32'h1000_0000 + cyc * 4;
        req_size_i = cyc[1:0]; req_fc_i = cyc[2:0]; req_ci_i = cif;
        if (dly == 0) ack_i = av;
        @(negedge clk);
        req_addr_i = 32'hDEAD_BEEF; req_size_i = 2'b11; req_fc_i = 3'b111; req_ci_i = ~cif;
        req_i = (stray > 0);
        for (int i = 1; i < dly; i++) begin
            if (i >= stray) req_i = 0;
            @(negedge clk);
        end
        req_i = 0;
        if (dly > 0) ack_i = av;
        wait_ph(6);
        if (hold >= 0) begin
            for (int i = 0; i < hold; i++) @(negedge clk);
            ack_i = 0;
            wait_ph(0);
            repeat (3) @(negedge clk);
        end else begin
            wait_ph(0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tst = "R1 reset state";
        chk("R1 reset as", {31'b0, as_o}, 32'd0);
        chk("R10 reset done", {31'b0, done_o}, 32'd0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        tst = "R5 ack with request, zero wait";
        run(2'b01, 0, 1, 0, 0);
        tst = "R4 ack on upper line, late";
        run(2'b10, 3, 2, 1, 0);
        tst = "R4 long wait";
        run(2'b01, 9, 0, 0, 0);
        tst = "R4 ack odd arrival";
        run(2'b11, 6, 1, 1, 0);
        tst = "R1 stray request during cycle";
        run(2'b10, 5, 1, 0, 4);
        tst = "R9 ack held into next request";
        run(2'b01, 0, -1, 1, 0);
        @(negedge clk);
        req_i = 1; req_addr_i = 32'h2000_0040; req_ci_i = 0;
        @(negedge clk);
        req_i = 0;
        repeat (6) @(negedge clk);
        ack_i = 0;
        repeat (3) @(negedge clk);
        ack_i = 2'b10;
        wait_ph(6);
        ack_i = 0;
        wait_ph(0);
        repeat (3) @(negedge clk);
        tst = "R6 R7 back to back";
        for (int k = 0; k < 4; k++) run(2'b01, k, 0, k[0], 0);
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog [%s] cycle %0d: actual hung expected finish", tst, cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule